// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a word-select line and one serial data line) and turns it into parallel samples. The left and right words share the data line in turn; word select tells them apart. The three wires are brought into the system clock domain through a two-flop synchroniser, and every rising edge of the bit clock is found there as a one-cycle event. The system clock must therefore run well above twice the bit rate. The stereo rates the block is meant for are about 2.8 Mbit/s at 44.1 kHz normal speed and about 5.6 Mbit/s at double speed.

Two framings are supported, chosen by a format input. In I2S framing the MSB comes first, one bit clock after the word-select change, and any word length up to 20 bits is accepted. In the right-justified framing the word ends on the last bit before the word-select change. Because the line rests on the MSB value before the word starts, the start cannot be seen on the line. The receiver keeps only the final 16, 18 or 20 bits, as set by a length input, and sign-extends them to 20 bits.

Each completed left/right pair appears on the two sample outputs together, marked by a one-cycle valid strobe. The outputs hold their values until the next pair arrives.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, both sample outputs read zero and the valid strobe is low until the first complete pair.
- R2: In I2S mode (fmt_i = 0), the bit sampled on the second bit-clock rising edge after a word-select change is the MSB. Word select low marks the left word and high marks the right word. A 20-bit word, whose LSB falls on the first rising edge after the next word-select change, is output unchanged.
- R3: In I2S mode, a word shorter than 20 bits is placed left-aligned in the 20-bit output, with the unused low bits set to zero. Any data bits after the word's LSB within the same slot group are zero.
- R4: In I2S mode, a word longer than 20 bits yields only its first 20 bits (the MSB end). All later bits are dropped.
- R5: In right-justified mode (fmt_i = 1) with len_i = 0 (16 bits), the last 16 bits before a word-select change form the word, sign-extended from bit 15 to 20 bits.
- R6: In right-justified mode with len_i = 1 (18 bits), the last 18 bits before a word-select change form the word, sign-extended from bit 17.
- R7: In right-justified mode with len_i = 2 or len_i = 3 (20 bits), the last 20 bits before a word-select change form the word. Any earlier bits in the same word-select phase have no effect.
- R8: valid_o is high for exactly one system clock after each right word completes, provided a left word was completed before it. Both outputs change only in that cycle and hold their values otherwise.
- R9: After reset, the word cut short by the first word-select change is discarded. A right word with no completed left word before it since reset produces no strobe and no output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| ws_i | input | 1 | Word select; 0 = left, 1 = right |
| sd_i | input | 1 | Serial data |
| fmt_i | input | 1 | Framing: 0 = I2S, 1 = right-justified |
| len_i | input | 2 | Right-justified length: 0 = 16, 1 = 18, 2 or 3 = 20 bits |
| left_o | output | 20 | Left sample of the last pair |
| right_o | output | 20 | Right sample of the last pair |
| valid_o | output | 1 | One-cycle strobe when a new pair is on the outputs |

## Verification
A sample pair is due three system clocks after the bit-clock rising edge that completes its right word: two synchroniser stages, then the register that loads the outputs and the strobe. The bench keeps each bit-clock phase four system clocks long, so one result cannot overlap the next edge. It pushes the expected pair into a queue before it sends the frame. The monitor samples on the falling system clock edge and compares only on a strobe, so the exact cycle count never has to be guessed. A strobe that finds the queue empty, a strobe two cycles long, or a pair still queued at the end of a test group is a failure. This covers the pairs that must be discarded at start-up.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_RJ  = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'd0,
        LEN_MID   = 2'd1,
        LEN_FULL  = 2'd2,
        LEN_FULLB = 2'd3
    } len_e;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sarx_edge.sv
module sarx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic ws_s,
    output logic rise_o,
    output logic ws_chg_o,
    output logic ws_last_o
);
    typedef struct packed {
        logic sck_prev;
        logic ws_last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        rise_o        = sck_s & ~st_q.sck_prev;
        ws_chg_o      = rise_o & (ws_s != st_q.ws_last);
        if (rise_o) st_d.ws_last = ws_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ws_last_o = st_q.ws_last;

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         ws_chg_i,
    input  logic         ws_last_i,
    input  logic         sd_i,
    input  fmt_e         fmt_i,
    input  len_e         len_i,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
        logic          armed;
        logic          left_got;
        logic [W-1:0]  left_hold;
        logic [W-1:0]  left;
        logic [W-1:0]  right;
        logic          valid;
    } rx_st_t;

    rx_st_t st_d, st_q;

    function automatic logic [W-1:0] rj_word(input logic [W-1:0] s, input len_e sel);
        int n;
        case (sel)
            LEN_SHORT: n = W - 4;
            LEN_MID:   n = W - 2;
            default:   n = W;
        endcase
        for (int i = 0; i < W; i++) begin
            rj_word[i] = (i < n) ? s[i] : s[n-1];
        end
    endfunction

    always_comb begin
        logic [W-1:0] ins;
        logic [W-1:0] word;
        st_d       = st_q;
        st_d.valid = 1'b0;
        ins        = st_q.sh;
        word       = '0;
        if (rise_i) begin
            if (fmt_i == FMT_I2S) begin
                if (st_q.cnt < CNT_MAX) ins[W-1-int'(st_q.cnt)] = sd_i;
                word = ins;
                if (ws_chg_i) begin
                    st_d.sh  = '0;
                    st_d.cnt = '0;
                end else begin
                    st_d.sh = ins;
                    if (st_q.cnt < CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                word    = rj_word(st_q.sh, len_i);
                st_d.sh = {st_q.sh[W-2:0], sd_i};
            end
            if (ws_chg_i) begin
                if (!st_q.armed) begin
                    st_d.armed = 1'b1;
                end else if (!ws_last_i) begin
                    st_d.left_hold = word;
                    st_d.left_got  = 1'b1;
                end else if (st_q.left_got) begin
                    st_d.left     = st_q.left_hold;
                    st_d.right    = word;
                    st_d.valid    = 1'b1;
                    st_d.left_got = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign valid_o = st_q.valid;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R8
    valid_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(rise_i));

    // R8
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> ($stable(st_q.left) && $stable(st_q.right)));

    // R9
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(st_q.left_got));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int DATA_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              ws_i,
    input  logic              sd_i,
    input  logic              fmt_i,
    input  logic [1:0]        len_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o
);
    logic [2:0] pins_s;
    logic       rise, ws_chg, ws_last;

    sarx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_i, ws_i, sd_i}),
        .dout  (pins_s)
    );

    sarx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[2]),
        .ws_s      (pins_s[1]),
        .rise_o    (rise),
        .ws_chg_o  (ws_chg),
        .ws_last_o (ws_last)
    );

    sarx_deser #(.W(DATA_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .ws_chg_i  (ws_chg),
        .ws_last_i (ws_last),
        .sd_i      (pins_s[0]),
        .fmt_i     (fmt_e'(fmt_i)),
        .len_i     (len_e'(len_i)),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o)
    );
endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, ws = 1'b1, sd = 1'b0, fmt = 1'b0;
    logic [1:0] len = 2'd0;
    logic [19:0] left_o, right_o;
    logic valid_o;

    always #2 clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
        .fmt_i(fmt), .len_i(len), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    typedef struct {
        logic [19:0] l;
        logic [19:0] r;
        string       req;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    logic carry = 1'b0;
    logic prev_valid = 1'b0;
    logic [19:0] last_l = '0, last_r = '0;
    bit done = 0;

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slot(input logic w, input logic b);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [23:0] mask(input logic [23:0] v, input int n);
        return v & ((24'd1 << n) - 24'd1);
    endfunction

    function automatic logic [19:0] exp_i2s(input logic [23:0] v, input int n);
        logic [23:0] t;
        if (n <= 20) t = v << (20 - n);
        else         t = v >> (n - 20);
        return t[19:0];
    endfunction

    function automatic logic [19:0] exp_rj(input logic [23:0] v, input int n);
        logic [19:0] t;
        for (int i = 0; i < 20; i++) t[i] = (i < n) ? v[i] : v[n-1];
        return t;
    endfunction

    task automatic i2s_half(input logic ch, input logic [23:0] v, input int n, input int slots);
        for (int k = 0; k < slots; k++) begin
            logic b;
            if (k == 0)      b = carry;
            else if (k <= n) b = v[n-k];
            else             b = 1'b0;
            slot(ch, b);
        end
        carry = (n >= slots) ? v[n-slots] : 1'b0;
    endtask

    task automatic rj_half(input logic ch, input logic [23:0] v, input int n, input int slots);
        for (int k = 0; k < slots; k++) begin
            int idx;
            idx = k - (slots - n);
            slot(ch, (idx < 0) ? logic'(k % 2) : v[n-1-idx]);
        end
    endtask

    task automatic start_group(input logic f, input logic [1:0] l, input logic idle_ws);
        @(negedge clk);
        rst_n = 1'b0; fmt = f; len = l; carry = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) slot(idle_ws, 1'b0);
    endtask

    task automatic end_group(input string req);
        for (int i = 0; i < 3; i++) slot(1'b0, (i == 0) ? carry : 1'b0);
        repeat (20) @(negedge clk);
        check({req, " pending pairs"}, 20'(q.size()), 20'd0);
        check("R8 left holds", left_o, last_l);
        check("R8 right holds", right_o, last_r);
        q.delete();
    endtask

    task automatic frames(input logic f, input int n, input int slots, input int lenrj,
                          input string req, input int seed);
        for (int fr = 0; fr < 3; fr++) begin
            logic [23:0] lv, rv;
            exp_t e;
            lv = mask(24'hA5C3E1 ^ (24'h13579B * (fr + seed)), n);
            rv = mask(24'h5A3C1E + (24'h2468AC * (fr + seed + 1)), n);
            if (fr == 1) rv = mask(24'hFFFFFF ^ rv, n);
            if (f == 1'b0) begin
                e.l = exp_i2s(lv, n); e.r = exp_i2s(rv, n);
            end else begin
                e.l = exp_rj(lv, lenrj); e.r = exp_rj(rv, lenrj);
            end
            e.req = req;
            q.push_back(e);
            last_l = e.l; last_r = e.r;
            if (f == 1'b0) begin
                i2s_half(1'b0, lv, n, slots);
                i2s_half(1'b1, rv, n, slots);
            end else begin
                rj_half(1'b0, lv, n, slots);
                rj_half(1'b1, rv, n, slots);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (prev_valid) begin
                    fails++; checks++;
                    $display("FAIL R8 strobe width actual=2 expected=1");
                end
                if (q.size() == 0) begin
                    fails++; checks++;
                    $display("FAIL R9 unexpected pair actual=%h/%h expected=none", left_o, right_o);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.req, " left"}, left_o, e.l);
                    check({e.req, " right"}, right_o, e.r);
                end
            end
            prev_valid = valid_o;
        end else begin
            prev_valid = 1'b0;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 left in reset", left_o, 20'd0);
        check("R1 right in reset", right_o, 20'd0);
        check("R1 valid in reset", 20'(valid_o), 20'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 left after reset", left_o, 20'd0);
        check("R1 valid after reset", 20'(valid_o), 20'd0);

        start_group(1'b0, 2'd0, 1'b1);
        frames(1'b0, 20, 20, 20, "R2", 1);
        end_group("R2");

        start_group(1'b0, 2'd0, 1'b1);
        frames(1'b0, 16, 24, 20, "R3", 4);
        end_group("R3");

        start_group(1'b0, 2'd0, 1'b1);
        frames(1'b0, 24, 24, 20, "R4", 7);
        end_group("R4");

        // R9: idle low, then a right word with no left word before it
        start_group(1'b1, 2'd0, 1'b0);
        rj_half(1'b1, 24'h00BEEF, 16, 24);
        frames(1'b1, 16, 24, 16, "R5", 9);
        end_group("R9");

        start_group(1'b1, 2'd1, 1'b1);
        frames(1'b1, 18, 24, 18, "R6", 12);
        end_group("R6");

        start_group(1'b1, 2'd2, 1'b1);
        frames(1'b1, 20, 24, 20, "R7", 15);
        end_group("R7");

        start_group(1'b1, 2'd3, 1'b1);
        frames(1'b1, 20, 22, 20, "R7", 18);
        end_group("R7");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule